// File: doc/BRIEF.md
# I2C Slave Address-Phase Controller

This block is the slave side of an I2C target. It watches the open-drain SCL and SDA lines, detects START and STOP conditions, and shifts in the address byte that follows each START. It compares that byte with a programmable own address, which can be 7 or 10 bits wide, and optionally with the general call address. It then decides whether to drive the acknowledge bit. After a match it stretches SCL low until the host has read the status register, and it raises an interrupt request if interrupts are enabled.

In the data phase that follows, the block stretches SCL again. In receive direction this happens after each byte until the data register is read. In transmit direction it happens before each byte until the data register is written. When DMA mode is selected, a request/acknowledge pair takes the place of the register access.

The controller starts only after its enable bit has been written twice. The first write arms it and the second activates it. Clock generation, master mode and arbitration are not part of this block.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, scl_oe_o, sda_oe_o, irq_o and dma_req_o are low and the status register (address 1) reads 0.
- R2: A write to the control register (address 0) with bit0 set only arms the block, and control bit6 reads 0. Bus traffic is ignored while armed: a matching address gets no acknowledge. A second such write activates the block and sets control bit6. A write with bit0 clear disarms and deactivates it.
- R3: In 7-bit mode (control bit4 = 0), an address byte whose upper seven bits equal own-address bits 6:0 is acknowledged by pulling SDA low during the ninth SCL clock. Status bit0 (selected) is set, and status bit3 takes the received R/W bit, with 1 meaning the slave transmits.
- R4: An address byte that matches nothing is not acknowledged. The controller returns to idle without stretching SCL, and status bit0 reads 0.
- R5: The byte 0x00 is acknowledged as a general call only when control bit3 is set. It then sets status bits 0 and 1.
- R6: In 10-bit mode (control bit4 = 1), a first byte of the form 11110 followed by own-address bits 9:8 and a write bit is acknowledged as a header without selecting the slave. A second byte equal to own-address bits 7:0 completes the match. After that match, a repeated START followed by the same header with the read bit selects the slave for transmission. A header carrying other upper address bits is not acknowledged.
- R7: Acknowledges are driven only when control bit1 is set. With bit1 clear, a matching address still sets status bit0, but SDA stays released during the ninth clock.
- R8: After a full address match, SCL is held low until status is read. If control bit2 is set, irq_o is high from the match until that read. Status bit4 shows the pending address event.
- R9: In receive direction, a data byte is taken MSB first. It is acknowledged per control bit1, SCL is held low, and status bit2 is set. Reading the data register (address 4) returns the byte and releases SCL.
- R10: In transmit direction, SCL is held low until the data register is written. The written byte is then driven on SDA MSB first. A master NACK on the ninth clock ends the transfer.
- R11: With control bit5 set, the data-phase hold raises dma_req_o instead of waiting for a register access. A one-cycle dma_ack_i clears the request and releases SCL. dma_rdata_o shows the received byte, and dma_wdata_i supplies the byte to transmit.
- R12: A STOP condition at any point clears status bit0, drops every hold and returns the controller to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (ACK or data 0) |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (read side effects) |
| reg_addr_i | input | 3 | Register select: 0 control, 1 status, 2 own address low, 3 own address high, 4 data |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Address-match interrupt request |
| dma_req_o | output | 1 | DMA transfer request |
| dma_ack_i | input | 1 | DMA acknowledge, one cycle |
| dma_wdata_i | input | 8 | Byte delivered by DMA for transmission |
| dma_rdata_o | output | 8 | Received byte offered to DMA |

## Verification
The assertions assume that SCL and SDA follow I2C line discipline. SDA changes only while SCL is low, except at START and STOP, and each SCL level lasts several system clocks, so the two-flop synchronizer sees every edge. They also assume that dma_ack_i arrives only while a request is pending. The bench master drives the lines through a wired-AND model with eight-clock half periods. It waits for SCL to be released before every rising edge, and it pulses the DMA acknowledge only after checking that a request is up. The random addresses and data bytes are generated inside these rules.

// File: rtl/i2c_sa_pkg.sv
package i2c_sa_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = $clog2(BYTE_W + 2);
  localparam int RADDR_W = 3;
  localparam int OWN_W   = 10;

  localparam logic [RADDR_W-1:0] RA_CTRL   = 3'd0;
  localparam logic [RADDR_W-1:0] RA_STAT   = 3'd1;
  localparam logic [RADDR_W-1:0] RA_OWN_LO = 3'd2;
  localparam logic [RADDR_W-1:0] RA_OWN_HI = 3'd3;
  localparam logic [RADDR_W-1:0] RA_DATA   = 3'd4;

  localparam logic [4:0] HDR10 = 5'b11110;

  typedef struct packed {
    logic dma;
    logic ten;
    logic gc;
    logic ie;
    logic ack;
  } ctrl_t;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ADDR2, S_RX, S_TX} st_e;
endpackage

// File: rtl/i2c_sa_sync.sv
module i2c_sa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_in;
  logic [LINES-1:0] line_s;
  logic [LINES-1:0] line_d;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q         <= '1;
        line_d[g] <= 1'b1;
      end else begin
        q         <= {q[STAGES-2:0], line_in[g]};
        line_d[g] <= q[STAGES-1];
      end
    end
    assign line_s[g] = q[STAGES-1];
  end

  assign scl_o      = line_s[0];
  assign sda_o      = line_s[1];
  assign scl_rise_o = line_s[0] & ~line_d[0];
  assign scl_fall_o = ~line_s[0] & line_d[0];
  assign start_o    = line_s[0] & line_d[0] & line_d[1] & ~line_s[1];
  assign stop_o     = line_s[0] & line_d[0] & ~line_d[1] & line_s[1];
endmodule

// File: rtl/i2c_sa_regs.sv
module i2c_sa_regs
  import i2c_sa_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [RADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0]  wdata_i,
  output ctrl_t              ctrl_o,
  output logic [OWN_W-1:0]   own_o,
  output logic               armed_o,
  output logic               active_o
);
  logic [OWN_W-9:0]  own_hi;
  logic [BYTE_W-1:0] own_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      armed_o  <= 1'b0;
      active_o <= 1'b0;
      own_lo   <= '0;
      own_hi   <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        RA_CTRL: begin
          ctrl_o <= wdata_i[5:1];
          if (!wdata_i[0]) begin
            armed_o  <= 1'b0;
            active_o <= 1'b0;
          end else if (armed_o) begin
            active_o <= 1'b1;
          end else begin
            armed_o  <= 1'b1;
          end
        end
        RA_OWN_LO: own_lo <= wdata_i;
        RA_OWN_HI: own_hi <= wdata_i[OWN_W-9:0];
        default: ;
      endcase
    end
  end

  assign own_o = {own_hi, own_lo};
endmodule

// File: rtl/i2c_sa_core.sv
module i2c_sa_core
  import i2c_sa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  ctrl_t             ctrl_i,
  input  logic [OWN_W-1:0]  own_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  input  logic              data_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              dma_ack_i,
  input  logic [BYTE_W-1:0] dma_wdata_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic              sel_o,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] rx_data_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  st_e               state, nxt;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg, txsh, rx_buf;
  logic tx_valid, ack_slot, sel, ten_sel, gcall, dir, addr_evt, hold_dr, rx_full, mst_ack;

  logic a7_hit, gc_hit, hdr_hit, lo_hit, dma_fire;

  assign a7_hit   = !ctrl_i.ten && (shreg[7:1] == own_i[6:0]);
  assign gc_hit   = ctrl_i.gc && (shreg == '0);
  assign hdr_hit  = ctrl_i.ten && (shreg[7:1] == {HDR10, own_i[9:8]});
  assign lo_hit   = (shreg == own_i[7:0]);
  assign dma_fire = dma_req_o && dma_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= S_IDLE;
      nxt      <= S_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      txsh     <= '0;
      rx_buf   <= '0;
      tx_valid <= 1'b0;
      ack_slot <= 1'b0;
      sel      <= 1'b0;
      ten_sel  <= 1'b0;
      gcall    <= 1'b0;
      dir      <= 1'b0;
      addr_evt <= 1'b0;
      hold_dr  <= 1'b0;
      rx_full  <= 1'b0;
      mst_ack  <= 1'b0;
    end else if (!active_i || stop_i) begin
      state    <= S_IDLE;
      bit_cnt  <= '0;
      ack_slot <= 1'b0;
      tx_valid <= 1'b0;
      hold_dr  <= 1'b0;
      addr_evt <= 1'b0;
      sel      <= 1'b0;
      ten_sel  <= 1'b0;
      gcall    <= 1'b0;
    end else if (start_i) begin
      state    <= S_ADDR;
      bit_cnt  <= '0;
      ack_slot <= 1'b0;
      tx_valid <= 1'b0;
      hold_dr  <= 1'b0;
    end else begin
      // host / DMA side
      if (stat_rd_i) addr_evt <= 1'b0;
      if (data_rd_i || (dma_fire && state == S_RX)) begin
        rx_full <= 1'b0;
        if (state == S_RX) hold_dr <= 1'b0;
      end
      if (state == S_TX && hold_dr && (data_wr_i || dma_fire)) begin
        txsh     <= dma_fire ? dma_wdata_i : wdata_i;
        tx_valid <= 1'b1;
        hold_dr  <= 1'b0;
      end
      // bus side
      if (scl_rise_i && state != S_IDLE) begin
        if (bit_cnt < LAST_BIT) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s_i};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (bit_cnt == LAST_BIT) begin
          bit_cnt <= ACK_BIT;
          mst_ack <= !sda_s_i;
        end
      end
      if (scl_fall_i && state != S_IDLE) begin
        if (bit_cnt == LAST_BIT) begin
          unique case (state)
            S_ADDR: begin
              if (gc_hit || a7_hit) begin
                sel      <= 1'b1;
                gcall    <= gc_hit;
                dir      <= shreg[0] && !gc_hit;
                addr_evt <= 1'b1;
                ack_slot <= ctrl_i.ack;
                ten_sel  <= 1'b0;
                nxt      <= (shreg[0] && !gc_hit) ? S_TX : S_RX;
              end else if (hdr_hit && !shreg[0]) begin
                ack_slot <= ctrl_i.ack;
                sel      <= 1'b0;
                ten_sel  <= 1'b0;
                nxt      <= S_ADDR2;
              end else if (hdr_hit && ten_sel) begin
                sel      <= 1'b1;
                gcall    <= 1'b0;
                dir      <= 1'b1;
                addr_evt <= 1'b1;
                ack_slot <= ctrl_i.ack;
                nxt      <= S_TX;
              end else begin
                state   <= S_IDLE;
                sel     <= 1'b0;
                ten_sel <= 1'b0;
                bit_cnt <= '0;
              end
            end
            S_ADDR2: begin
              if (lo_hit) begin
                sel      <= 1'b1;
                ten_sel  <= 1'b1;
                gcall    <= 1'b0;
                dir      <= 1'b0;
                addr_evt <= 1'b1;
                ack_slot <= ctrl_i.ack;
                nxt      <= S_RX;
              end else begin
                state   <= S_IDLE;
                sel     <= 1'b0;
                bit_cnt <= '0;
              end
            end
            S_RX: begin
              rx_buf   <= shreg;
              rx_full  <= 1'b1;
              ack_slot <= ctrl_i.ack;
            end
            S_TX: tx_valid <= 1'b0;
            default: ;
          endcase
        end else if (bit_cnt == ACK_BIT) begin
          ack_slot <= 1'b0;
          bit_cnt  <= '0;
          unique case (state)
            S_ADDR, S_ADDR2: begin
              state <= nxt;
              if (nxt == S_TX) hold_dr <= 1'b1;
            end
            S_RX: hold_dr <= 1'b1;
            S_TX: begin
              if (mst_ack) hold_dr <= 1'b1;
              else state <= S_IDLE;
            end
            default: ;
          endcase
        end else if (state == S_TX && bit_cnt != '0) begin
          txsh <= {txsh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign scl_oe_o  = active_i && (hold_dr ||
                     (addr_evt && bit_cnt == '0 && (state == S_RX || state == S_TX)));
  assign sda_oe_o  = active_i && (ack_slot || (state == S_TX && tx_valid && !txsh[BYTE_W-1]));
  assign irq_o     = active_i && ctrl_i.ie && addr_evt;
  assign dma_req_o = active_i && ctrl_i.dma && hold_dr && !addr_evt;
  assign sel_o     = sel;
  assign status_o  = {3'b000, addr_evt, dir, rx_full, gcall, sel};
  assign rx_data_o = rx_buf;
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2c_sa_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        irq_o,
  output logic        dma_req_o,
  input  logic        dma_ack_i,
  input  logic [7:0]  dma_wdata_i,
  output logic [7:0]  dma_rdata_o
);
  ctrl_t             ctrl;
  logic [OWN_W-1:0]  own;
  logic              armed, active;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              sel;
  logic [BYTE_W-1:0] status, rx_data;

  i2c_sa_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_sa_regs u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .ctrl_o(ctrl), .own_o(own), .armed_o(armed), .active_o(active)
  );

  i2c_sa_core u_core (
    .clk_i, .rst_ni, .active_i(active), .ctrl_i(ctrl), .own_i(own),
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .stat_rd_i(reg_re_i && reg_addr_i == RA_STAT),
    .data_rd_i(reg_re_i && reg_addr_i == RA_DATA),
    .data_wr_i(reg_we_i && reg_addr_i == RA_DATA),
    .wdata_i(reg_wdata_i), .dma_ack_i, .dma_wdata_i,
    .scl_oe_o, .sda_oe_o, .irq_o, .dma_req_o, .sel_o(sel),
    .status_o(status), .rx_data_o(rx_data)
  );

  always_comb begin
    unique case (reg_addr_i)
      RA_CTRL:   reg_rdata_o = {1'b0, active, ctrl, armed};
      RA_STAT:   reg_rdata_o = status;
      RA_OWN_LO: reg_rdata_o = own[7:0];
      RA_OWN_HI: reg_rdata_o = {6'b0, own[9:8]};
      RA_DATA:   reg_rdata_o = rx_data;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign dma_rdata_o = rx_data;
endmodule

// File: rtl/i2c_addr_slave_chk.sv
module i2c_addr_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic active,
  input logic ctrl_dma,
  input logic ctrl_ie,
  input logic scl_s,
  input logic stop_det,
  input logic sel,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic irq_o,
  input logic dma_req_o
);
  // R2: nothing is driven while not active
  a_r2_quiet_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !scl_oe_o && !sda_oe_o && !irq_o && !dma_req_o);
  // R11
  a_r11_req_needs_dma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> ctrl_dma);
  a_r11_req_stretches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> scl_oe_o);
  // R8
  a_r8_irq_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_ie);
  // R12
  a_r12_stop_deselects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sel);
  // R3: SDA drive changes only while SCL is low
  a_r3_sda_rise_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni || !active)
    $rose(sda_oe_o) |-> !scl_s);
  a_r3_sda_fall_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni || !active)
    $fell(sda_oe_o) |-> !scl_s);
endmodule

bind i2c_addr_slave i2c_addr_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .active(active), .ctrl_dma(ctrl.dma), .ctrl_ie(ctrl.ie),
  .scl_s(scl_s), .stop_det(stop_det), .sel(sel), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
  .irq_o(irq_o), .dma_req_o(dma_req_o)
);

// File: tb/i2c_addr_slave_test.sv
`timescale 1ns/1ps
module i2c_addr_slave_test;
  localparam int H = 8;
  localparam logic [7:0] C_EN = 8'h01, C_ACK = 8'h02, C_IE = 8'h04, C_GC = 8'h08,
                         C_TEN = 8'h10, C_DMA = 8'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe_o, sda_oe_o, irq_o, dma_req_o;
  logic reg_we = 1'b0, reg_re = 1'b0, dma_ack = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata_o, dma_wdata = '0, dma_rdata_o;
  logic scl_line, sda_line;
  int n_tests = 0, n_fail = 0;
  int cyc = 0;

  assign scl_line = m_scl & ~scl_oe_o;
  assign sda_line = m_sda & ~sda_oe_o;

  always #4 clk = ~clk;

  i2c_addr_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata_o),
    .irq_o(irq_o), .dma_req_o(dma_req_o), .dma_ack_i(dma_ack),
    .dma_wdata_i(dma_wdata), .dma_rdata_o(dma_rdata_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_match7(input logic [6:0] own, input logic [7:0] b, input logic gc);
    return (b[7:1] == own) || (gc && b == 8'h00);
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata_o;
    @(negedge clk); reg_re = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_free();
    while (scl_oe_o) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b;
    repeat (H) @(negedge clk);
    wait_free();
    m_scl = 1'b1;
    repeat (H) @(negedge clk);
    r = sda_line;
    m_scl = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic start_c();
    m_sda = 1'b1;
    repeat (H) @(negedge clk);
    wait_free();
    m_scl = 1'b1;
    repeat (H) @(negedge clk);
    m_sda = 1'b0;
    repeat (H) @(negedge clk);
    m_scl = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic stop_c();
    m_sda = 1'b0;
    repeat (H) @(negedge clk);
    wait_free();
    m_scl = 1'b1;
    repeat (H) @(negedge clk);
    m_sda = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      b[i] = r;
    end
    clk_bit(!give_ack, r);
  endtask

  initial begin
    logic [7:0] d, own7, tgt, dat;
    logic ack, m;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 scl_oe", scl_oe_o, 0);
    check("R1 sda_oe", sda_oe_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 dma_req", dma_req_o, 0);
    reg_read(3'd1, d); check("R1 status", d, 8'h00);

    // R2 single enable write only arms
    reg_write(3'd2, 8'h3A);
    reg_write(3'd0, C_EN | C_ACK | C_IE);
    reg_read(3'd0, d); check("R2 armed not active", d[6:0], 7'h07);
    start_c(); send_byte({7'h3A, 1'b0}, ack); stop_c();
    check("R2 no ack while armed", ack, 0);
    reg_write(3'd0, C_EN | C_ACK | C_IE);
    reg_read(3'd0, d); check("R2 active bit", d[6], 1);

    // random 7-bit address and receive traffic (R3 R4 R8 R9 R12)
    for (int it = 0; it < 8; it++) begin
      own7 = 7'($urandom % 128);
      tgt  = ($urandom % 2 == 0) ? {own7, 1'b0} : 8'({$urandom % 128, 1'b0});
      dat  = 8'($urandom);
      m    = exp_match7(own7, tgt, 1'b0);
      reg_write(3'd2, {1'b0, own7});
      start_c(); send_byte(tgt, ack);
      check("R3/R4 address ack", ack, m);
      check("R8/R4 stretch after address", scl_oe_o, m);
      if (m) begin
        check("R8 irq raised", irq_o, 1);
        reg_read(3'd1, d); check("R3 status sel/dir", d & 8'h19, 8'h11);
        check("R8 released by status read", scl_oe_o, 0);
        check("R8 irq cleared", irq_o, 0);
        send_byte(dat, ack);
        check("R9 data ack", ack, 1);
        check("R9 stretch after byte", scl_oe_o, 1);
        reg_read(3'd1, d); check("R9 rx_full", d[2], 1);
        reg_read(3'd4, d); check("R9 data value", d, dat);
        check("R9 released by data read", scl_oe_o, 0);
      end else begin
        reg_read(3'd1, d); check("R4 not selected", d[0], 0);
      end
      stop_c();
      reg_read(3'd1, d); check("R12 sel cleared by stop", d[0], 0);
    end

    // R5 general call
    reg_write(3'd2, 8'h3A);
    start_c(); send_byte(8'h00, ack); stop_c();
    check("R5 gc ignored when disabled", ack, 0);
    reg_write(3'd0, C_EN | C_ACK | C_GC);
    start_c(); send_byte(8'h00, ack);
    check("R5 gc acked", ack, 1);
    reg_read(3'd1, d); check("R5 gc status", d[1:0], 2'b11);
    stop_c();

    // R7 acknowledge disabled
    reg_write(3'd0, C_EN);
    start_c(); send_byte({7'h3A, 1'b0}, ack);
    check("R7 no ack when disabled", ack, 0);
    reg_read(3'd1, d); check("R7 still selected", d[0], 1);
    stop_c();

    // R10 transmit
    reg_write(3'd0, C_EN | C_ACK);
    start_c(); send_byte({7'h3A, 1'b1}, ack);
    check("R10 read address ack", ack, 1);
    reg_read(3'd1, d); check("R10 dir bit", d[3], 1);
    check("R10 held until data write", scl_oe_o, 1);
    reg_write(3'd4, 8'hA5);
    recv_byte(1'b0, d);
    check("R10 transmitted byte", d, 8'hA5);
    stop_c();

    // R6 10-bit addressing
    reg_write(3'd3, 8'h02);
    reg_write(3'd2, 8'h5C);
    reg_write(3'd0, C_EN | C_ACK | C_TEN);
    start_c(); send_byte(8'hF4, ack);
    check("R6 header ack", ack, 1);
    check("R6 no stretch on header", scl_oe_o, 0);
    reg_read(3'd1, d); check("R6 header not selected", d[0], 0);
    send_byte(8'h5C, ack);
    check("R6 low byte ack", ack, 1);
    reg_read(3'd1, d); check("R6 selected", d[0], 1);
    start_c(); send_byte(8'hF5, ack);
    check("R6 read header ack", ack, 1);
    reg_read(3'd1, d); check("R6 read dir", d[3], 1);
    reg_write(3'd4, 8'h3C);
    recv_byte(1'b0, d);
    check("R6 10-bit transmit", d, 8'h3C);
    stop_c();
    start_c(); send_byte(8'hF2, ack); stop_c();
    check("R6 wrong header nack", ack, 0);

    // R11 DMA mode
    reg_write(3'd2, 8'h3A);
    reg_write(3'd0, C_EN | C_ACK | C_DMA);
    start_c(); send_byte({7'h3A, 1'b0}, ack);
    check("R11 no req during address hold", dma_req_o, 0);
    reg_read(3'd1, d);
    send_byte(8'h96, ack);
    check("R11 dma req", dma_req_o, 1);
    check("R11 dma data", dma_rdata_o, 8'h96);
    check("R11 stretch while req", scl_oe_o, 1);
    if (dma_req_o) begin
      @(negedge clk); dma_ack = 1'b1;
      @(negedge clk); dma_ack = 1'b0;
    end
    @(negedge clk);
    check("R11 req cleared", dma_req_o, 0);
    check("R11 released", scl_oe_o, 0);
    stop_c();

    // R2 disable
    reg_write(3'd0, 8'h00);
    reg_read(3'd0, d); check("R2 disabled", d[6], 0);
    start_c(); send_byte({7'h3A, 1'b0}, ack); stop_c();
    check("R2 no ack when disabled", ack, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule